// File: doc/BRIEF.md
# AGC Envelope Estimator with Asymmetric Attack and Decay

This block follows the amplitude of a stream of signed samples with a single-pole estimator. It then turns the distance between that estimate and a programmable reference level into an unsigned attenuation request for an automatic gain control loop. The estimate moves quickly toward a louder input at the attack rate. It relaxes toward a quieter input at a slower decay rate. The decay rate is derived from the attack rate in half-octave steps, so the decay time can be set anywhere from equal to the attack time up to roughly 180 times longer.

A 4-bit attack code sets the loop speed in binary steps, where a larger code gives a slower loop. A 4-bit decay code sets the decay-to-attack ratio. A converter overload can be reported with a one-cycle event pulse. Each such pulse adds a fixed step of attenuation, and that step doubles for every increment of a 3-bit overload weight code. The estimate and the attenuation request are both registered and are both brought out. Both update only when a valid sample arrives, apart from overload steps, which are applied whenever an event pulse occurs.

Top module: `agc_env_tracker`

## Requirements
- R1: A synchronous active-high reset clears both the estimate and the attenuation word to 0. Samples and overload pulses present during reset have no effect.
- R2: The estimator uses the magnitude of the sample as a two's-complement value. The most negative input gives a magnitude of 2^(DW-1). That magnitude is placed in the upper DW bits of the EW-bit estimate scale (FRAC fraction bits).
- R3: With a valid sample whose scaled magnitude M exceeds the estimate E, the new estimate is E + ((M - E) >>> attack_code). The shift is arithmetic and floors. The new estimate is visible one clock after the valid cycle.
- R4: With a valid sample where M <= E and an even decay code d, the new estimate is E + ((M - E) >>> (attack_code + d/2)), where d/2 is rounded down.
- R5: With a valid sample where M <= E and an odd decay code d, the shifted term t = (M - E) >>> (attack_code + (d-1)/2) is further scaled to (t * 23170) >>> 15. This scaling multiplies by about 0.7071 and floors.
- R6: When the valid strobe is low, the sample input has no effect. The estimate and the attenuation word both hold.
- R7: One clock after each estimate update, the attenuation word A becomes A + ((E - L) >>> attack_code). Here E is the updated estimate and L is the reference level, and the shift is arithmetic and floors.
- R8: An overload pulse adds OVL_BASE << overload_code to the attenuation word on the clock edge that samples it. If a loop step falls on the same edge, both are summed before saturation.
- R9: The attenuation word saturates at 0 and at 2^GW - 1 and never wraps. The estimate likewise saturates at 0 and at 2^EW - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Signed sample |
| atk_code | input | 4 | Attack code: loop shift, larger is slower |
| dec_code | input | 4 | Decay ratio code, half-octave steps |
| ovl_code | input | 3 | Overload step weight code |
| ovl_evt | input | 1 | One-cycle overload event pulse |
| lvl_ref | input | EW | Reference level on the estimate scale |
| env_est | output | EW | Registered amplitude estimate |
| gain_word | output | GW | Registered attenuation request |

## Verification
A wrong estimator state shows up on the estimate port one clock after the offending valid sample. It reaches the attenuation word one clock later, because the loop integrates the estimate's error against the reference. Errors in the branch choice, the half-octave multiply or the shift amount therefore show up as an exact numeric mismatch within two cycles of a single sample. A wrong overload weight or a clamp that wraps shows up on the attenuation word on the edge after the event. The bench drives isolated samples and compares both ports against a bit-exact model built from the requirements.

// File: rtl/agc_env_pkg.sv
package agc_env_pkg;
  // Half-octave factor 1/sqrt(2) in Q1.15
  localparam int unsigned RT2_Q = 15;
  localparam logic signed [16:0] RT2_COEF = 17'sd23170;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned OVL_W  = 3;
endpackage

// File: rtl/agc_magnitude.sv
module agc_magnitude #(
  parameter int unsigned DW = 16
) (
  input  logic signed [DW-1:0] smp,
  output logic        [DW-1:0] mag
);
  // One extra bit so the most negative code has a representable magnitude
  logic signed [DW:0] wide;
  logic signed [DW:0] absval;

  assign wide   = {smp[DW-1], smp};
  assign absval = wide[DW] ? -wide : wide;
  assign mag    = DW'(absval);
endmodule

// File: rtl/agc_envelope.sv
module agc_envelope
  import agc_env_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned FRAC = 8,
  localparam int unsigned EW  = DW + FRAC,
  localparam int unsigned PW  = EW + 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW-1:0]     mag,
  input  logic [CODE_W-1:0] atk,
  input  logic [CODE_W-1:0] dec,
  output logic [EW-1:0]     est
);
  localparam logic signed [EW+1:0] EMAX = {2'b00, {EW{1'b1}}};

  logic [EW-1:0]          est_q;
  logic [EW-1:0]          mag_ext;
  logic signed [EW:0]     err;
  logic [CODE_W:0]        dsh;
  logic signed [EW:0]     t_atk;
  logic signed [EW:0]     t_dec0;
  logic signed [EW:0]     t_odd;
  logic signed [EW:0]     delta;
  logic signed [EW+1:0]   nxt;
  logic                   rising;

  assign mag_ext = EW'(mag) << FRAC;
  assign err     = $signed({1'b0, mag_ext}) - $signed({1'b0, est_q});
  assign rising  = mag_ext > est_q;
  assign dsh     = {1'b0, atk} + {2'b00, dec[CODE_W-1:1]};
  assign t_atk   = err >>> atk;
  assign t_dec0  = err >>> dsh;
  assign t_odd   = (EW+1)'((PW'(t_dec0) * PW'(RT2_COEF)) >>> RT2_Q);

  always_comb begin
    if (rising)      delta = t_atk;
    else if (dec[0]) delta = t_odd;
    else             delta = t_dec0;
  end

  assign nxt = $signed({2'b00, est_q}) + {delta[EW], delta};

  always_ff @(posedge clk) begin
    if (rst) begin
      est_q <= '0;
    end else if (in_valid) begin
      if (nxt < 0)         est_q <= '0;
      else if (nxt > EMAX) est_q <= '1;
      else                 est_q <= nxt[EW-1:0];
    end
  end

  assign est = est_q;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> est_q == '0);
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(est_q));
  assert_attack_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && (mag_ext > est_q) |=> (est_q >= $past(est_q)) && (est_q <= $past(mag_ext)));
  assert_decay_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (mag_ext < est_q) |=> (est_q < $past(est_q)) && (est_q >= $past(mag_ext)));
endmodule

// File: rtl/agc_gain_acc.sv
module agc_gain_acc
  import agc_env_pkg::*;
#(
  parameter int unsigned EW       = 24,
  parameter int unsigned GW       = 16,
  parameter int unsigned OVL_BASE = 256,
  localparam int unsigned AW      = EW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [EW-1:0]     est,
  input  logic [EW-1:0]     lvl_ref,
  input  logic [CODE_W-1:0] atk,
  input  logic              ovl_evt,
  input  logic [OVL_W-1:0]  ovl_code,
  output logic [GW-1:0]     gain
);
  localparam logic signed [AW-1:0] GMAX = $signed({{(AW-GW){1'b0}}, {GW{1'b1}}});

  logic [GW-1:0]          acc_q;
  logic signed [EW:0]     diff;
  logic signed [EW:0]     step;
  logic [AW-1:0]          ovl_add;
  logic signed [AW-1:0]   step_x;
  logic signed [AW-1:0]   ovl_x;
  logic signed [AW-1:0]   sum;

  assign diff    = $signed({1'b0, est}) - $signed({1'b0, lvl_ref});
  assign step    = diff >>> atk;
  assign ovl_add = AW'(OVL_BASE) << ovl_code;
  assign step_x  = upd ? {{(AW-EW-1){step[EW]}}, step} : '0;
  assign ovl_x   = ovl_evt ? $signed(ovl_add) : '0;
  assign sum     = $signed({{(AW-GW){1'b0}}, acc_q}) + step_x + ovl_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (upd || ovl_evt) begin
      if (sum < 0)         acc_q <= '0;
      else if (sum > GMAX) acc_q <= '1;
      else                 acc_q <= sum[GW-1:0];
    end
  end

  assign gain = acc_q;

  assert_reset_clear_gain_R1: assert property (@(posedge clk) rst |=> acc_q == '0);
  assert_ovl_raises_R8: assert property (@(posedge clk) disable iff (rst)
    ovl_evt && !upd |=> (acc_q > $past(acc_q)) || (acc_q == '1));
  assert_below_ref_lowers_R7: assert property (@(posedge clk) disable iff (rst)
    upd && !ovl_evt && (est < lvl_ref) |=> acc_q <= $past(acc_q));
  assert_no_wrap_up_R9: assert property (@(posedge clk) disable iff (rst)
    !upd && ovl_evt && ($past(acc_q) == '1) |=> acc_q == '1);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !upd && !ovl_evt |=> $stable(acc_q));
endmodule

// File: rtl/agc_env_tracker.sv
module agc_env_tracker
  import agc_env_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned FRAC     = 8,
  parameter int unsigned GW       = 16,
  parameter int unsigned OVL_BASE = 256,
  localparam int unsigned EW      = DW + FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic [3:0]           atk_code,
  input  logic [3:0]           dec_code,
  input  logic [2:0]           ovl_code,
  input  logic                 ovl_evt,
  input  logic [EW-1:0]        lvl_ref,
  output logic [EW-1:0]        env_est,
  output logic [GW-1:0]        gain_word
);
  logic [DW-1:0] mag;
  logic          upd_q;

  agc_magnitude #(.DW(DW)) u_mag (
    .smp (smp_data),
    .mag (mag)
  );

  agc_envelope #(.DW(DW), .FRAC(FRAC)) u_env (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .mag      (mag),
    .atk      (atk_code),
    .dec      (dec_code),
    .est      (env_est)
  );

  // Loop update follows the estimate register by one cycle
  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= smp_valid;
  end

  agc_gain_acc #(.EW(EW), .GW(GW), .OVL_BASE(OVL_BASE)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd_q),
    .est      (env_est),
    .lvl_ref  (lvl_ref),
    .atk      (atk_code),
    .ovl_evt  (ovl_evt),
    .ovl_code (ovl_code),
    .gain     (gain_word)
  );

  assert_upd_follows_R7: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> upd_q);
endmodule

// File: tb/sim_agc_env_tracker.sv
module sim_agc_env_tracker;
  localparam int DW = 16;
  localparam int FRAC = 8;
  localparam int EW = DW + FRAC;
  localparam int GW = 16;
  localparam longint OVLB = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic [3:0] atk_code = '0;
  logic [3:0] dec_code = '0;
  logic [2:0] ovl_code = '0;
  logic ovl_evt = 1'b0;
  logic [EW-1:0] lvl_ref = '0;
  logic [EW-1:0] env_est;
  logic [GW-1:0] gain_word;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint m_est = 0;
  longint m_acc = 0;

  always #5 clk = ~clk;

  agc_env_tracker u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .atk_code(atk_code), .dec_code(dec_code), .ovl_code(ovl_code),
    .ovl_evt(ovl_evt), .lvl_ref(lvl_ref), .env_est(env_est), .gain_word(gain_word)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mdl_est(input longint x);
    longint m, e, t;
    int sh;
    m = ((x < 0) ? -x : x) * (64'sd1 << FRAC);
    e = m - m_est;
    if (e > 0) t = e >>> atk_code;
    else begin
      sh = int'(atk_code) + int'(dec_code) / 2;
      t = e >>> sh;
      if (dec_code[0]) t = (t * 23170) >>> 15;
    end
    m_est = m_est + t;
    if (m_est < 0) m_est = 0;
    if (m_est > (64'sd1 << EW) - 1) m_est = (64'sd1 << EW) - 1;
  endtask

  task automatic mdl_acc(input bit stp, input bit ovl);
    if (stp) m_acc = m_acc + ((m_est - longint'(lvl_ref)) >>> atk_code);
    if (ovl) m_acc = m_acc + (OVLB << ovl_code);
    if (m_acc < 0) m_acc = 0;
    if (m_acc > (64'sd1 << GW) - 1) m_acc = (64'sd1 << GW) - 1;
  endtask

  task automatic send(input int x, input string te, input string tg);
    @(negedge clk); smp_valid = 1'b1; smp_data = DW'(x);
    @(negedge clk); smp_valid = 1'b0;
    mdl_est(longint'(x));
    chk(te, longint'(env_est), m_est);
    @(negedge clk);
    mdl_acc(1'b1, 1'b0);
    chk(tg, longint'(gain_word), m_acc);
  endtask

  task automatic pulse_ovl(input string tg);
    @(negedge clk); ovl_evt = 1'b1;
    @(negedge clk); ovl_evt = 1'b0;
    mdl_acc(1'b0, 1'b1);
    chk(tg, longint'(gain_word), m_acc);
  endtask

  task automatic t_reset;
    rst = 1'b1; smp_valid = 1'b1; smp_data = 16'sd5000; ovl_evt = 1'b1;
    repeat (3) @(negedge clk);
    smp_valid = 1'b0; ovl_evt = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_est = 0; m_acc = 0;
    chk("R1 est", longint'(env_est), 0);
    chk("R1 gain", longint'(gain_word), 0);
  endtask

  task automatic t_attack;
    atk_code = 4'd0; dec_code = 4'd0; lvl_ref = '0;
    send(1, "R3 attack full", "R7 gain up");
    atk_code = 4'd3;
    send(3, "R3 attack shift3", "R7 gain step");
    send(-32768, "R2 most negative", "R9 gain top clamp");
    send(32767, "R2 positive max", "R9 gain held top");
  endtask

  task automatic t_decay;
    atk_code = 4'd1; dec_code = 4'd2; lvl_ref = 24'hFFFFFF;
    send(0, "R4 decay even", "R9 gain bottom clamp");
    dec_code = 4'd3;
    send(100, "R5 decay odd", "R7 gain down");
    dec_code = 4'd15; atk_code = 4'd7;
    send(0, "R5 decay code15", "R7 gain after code15");
    dec_code = 4'd8; atk_code = 4'd0;
    send(0, "R4 decay code8", "R7 gain after code8");
  endtask

  task automatic t_idle;
    longint e0, g0;
    e0 = longint'(env_est); g0 = longint'(gain_word);
    @(negedge clk); smp_valid = 1'b0; smp_data = 16'sd12345;
    repeat (3) @(negedge clk);
    smp_data = -16'sd20000;
    repeat (2) @(negedge clk);
    chk("R6 est hold", longint'(env_est), e0);
    chk("R6 gain hold", longint'(gain_word), g0);
  endtask

  task automatic t_overload;
    ovl_code = 3'd0;
    pulse_ovl("R8 code0 step");
    ovl_code = 3'd3;
    pulse_ovl("R8 code3 step");
    ovl_code = 3'd7;
    pulse_ovl("R8 code7 step");
    pulse_ovl("R9 ovl top clamp");
  endtask

  task automatic t_coincide;
    // Loop step and overload land on the same edge
    atk_code = 4'd2; dec_code = 4'd0; ovl_code = 3'd5;
    lvl_ref = 24'd2000000;
    @(negedge clk); smp_valid = 1'b1; smp_data = 16'sd100;
    @(negedge clk); smp_valid = 1'b0; ovl_evt = 1'b1;
    mdl_est(100);
    chk("R4 decay before coincide", longint'(env_est), m_est);
    @(negedge clk); ovl_evt = 1'b0;
    mdl_acc(1'b1, 1'b1);
    chk("R8 coincident sum", longint'(gain_word), m_acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_attack();
    t_idle();
    t_decay();
    t_overload();
    t_coincide();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule